// File: doc/BRIEF.md
# Scanned Keyboard and Display Controller

This block sits between a host bus and a keyboard matrix plus a multiplexed character display. One scan counter steps through the matrix rows and the display digits together. Each row of up to eight return lines is sampled at the end of its scan slot. A key that is seen closed on two consecutive visits to its row becomes one code in an eight-entry first-in first-out queue. The host reads that queue and is told through an interrupt line that codes are waiting.

The host writes display characters into a sixteen-entry by eight-bit RAM. Each character is shown as two nibbles while its digit is scanned, and a blanking output hides the change from one digit to the next. A strobed-input mode turns scanning off for the keyboard: each falling edge of the control/strobe line pushes the raw return-line byte into the queue.

Top module: `kbd_disp_ctrl`

## Requirements
- R1: After reset the scan output is 0, blank is 1, the interrupt is 0, the status byte reads 0x00 and both display nibbles are 0. The mode is then encoded scan, scanned keyboard, 8 digits and left entry.
- R2: The queue holds 8 bytes in first-in first-out order. A data read (a0=0, rd_n low) shows the oldest entry on dout and removes it at that clock edge.
- R3: A status read (a0=1) returns the overrun flag in bit 7 and the entry count in bits 6:0. A status read clears the overrun flag.
- R4: irq is 1 exactly when the queue holds at least one entry.
- R5: A bus read or write has no effect while cs_n is high.
- R6: In scanned mode a key is pushed only after it is seen closed on two consecutive scans of its row. A key held down gives one entry. The entry is {ctrl_key, shift_key, row[2:0], column[2:0]}, where a return line is 1 when its key is closed.
- R7: In strobed mode (mode bit 1) each falling edge of ctrl_key pushes the current ret byte.
- R8: A push into a full queue drops the byte and sets the sticky overrun flag.
- R9: A control write with din[7:4]=0x8 loads the display address from din[3:0]. In left entry, a data write stores din at that address, then the address rises by one, wrapping at the digit count.
- R10: In right entry (mode bit 3), a data write places din in the last digit and shifts every other digit down one place.
- R11: disp_hi and disp_lo show the upper and lower nibbles of the RAM entry at the current scan position.
- R12: A control write with din[7:4]=0x0 sets the mode from din[3:0]: bit 0 decoded scan, bit 1 strobed input, bit 2 sixteen digits, bit 3 right entry. In encoded form scan counts 0..7, or 0..15 with sixteen digits. In decoded form scan is one-hot over 4 positions. The scan position steps every SCAN_DIV clocks.
- R13: blank is 1 in the first clock of every scan slot, which includes every clock in which the scan output has just changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | 0 selects data, 1 selects control/status |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data (queue head or status) |
| irq | output | 1 | Queue not empty |
| scan | output | 4 | Scan lines to the matrix and the digit drivers |
| ret | input | 8 | Return lines, 1 = key closed |
| shift_key | input | 1 | Shift key level |
| ctrl_key | input | 1 | Control key level, strobe in strobed mode |
| disp_hi | output | 4 | Upper nibble of the scanned digit |
| disp_lo | output | 4 | Lower nibble of the scanned digit |
| blank | output | 1 | Display blanking |

## Verification
The assertions check on every cycle that the queue count never exceeds its depth and that a push into a full queue raises overrun. They also check that overrun stays set until a status read and that a status read clears it. The remaining per-cycle checks are that blanking accompanies every scan step, that decoded scan stays one-hot, and that left-entry writes advance the address by one. Only the bench scenarios can show the debounce outcome and the entry codes: a key held over three scans gives one correct code, while a press lasting a single scan gives nothing. The same applies to strobe capture order, address wrap, the right-entry shift, and the nibbles that appear on the display outputs at each digit.

// File: rtl/kbd_disp_ctrl.sv
module kbd_disp_ctrl #(
  parameter int SCAN_DIV   = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       a0,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       irq,
  output logic [3:0] scan,
  input  logic [7:0] ret,
  input  logic       shift_key,
  input  logic       ctrl_key,
  output logic [3:0] disp_hi,
  output logic [3:0] disp_lo,
  output logic       blank
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int DW = $clog2(SCAN_DIV);

  logic [3:0] mode;   // [0] decoded [1] strobed [2] sixteen digits [3] right entry
  logic [3:0] addr, sc;
  logic [DW-1:0] div;
  logic [7:0] ram [16];
  logic [7:0] prev [8];
  logic [7:0] rep [8];
  logic [7:0] fifo [FIFO_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic ovr, stb_q;
  logic [2:0] col;

  wire wr_cmd   = !cs_n && !wr_n && a0;
  wire wr_dat   = !cs_n && !wr_n && !a0;
  wire rd_st    = !cs_n && !rd_n && a0;
  wire rd_dat   = !cs_n && !rd_n && !a0;
  wire [4:0] ndig  = mode[0] ? 5'd4 : (mode[2] ? 5'd16 : 5'd8);
  wire [3:0] dmask = 4'(ndig - 5'd1);
  wire slot_end = (div == DW'(SCAN_DIV - 1));
  wire [2:0] row = mode[0] ? {1'b0, sc[1:0]} : sc[2:0];
  wire [7:0] fresh = ret & prev[row] & ~rep[row];
  wire [7:0] pick  = fresh & (~fresh + 8'd1);
  wire full     = (cnt == CW'(FIFO_DEPTH));
  wire push     = mode[1] ? (stb_q && !ctrl_key) : (slot_end && (|fresh));
  wire do_push  = push && !full;
  wire pop      = rd_dat && (cnt != '0);
  wire [7:0] pdata = mode[1] ? ret : {ctrl_key, shift_key, row, col};

  always_comb begin
    col = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (fresh[i]) col = 3'(i);
  end

  assign scan    = mode[0] ? (4'b0001 << sc[1:0]) : sc;
  assign blank   = (div == '0);
  assign disp_hi = ram[sc][7:4];
  assign disp_lo = ram[sc][3:0];
  assign irq     = (cnt != '0);
  assign dout    = a0 ? {ovr, 7'(cnt)} : fifo[rp];

  // scan counter and key history
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      div <= '0;
      sc  <= '0;
      for (int r = 0; r < 8; r++) begin
        prev[r] <= '0;
        rep[r]  <= '0;
      end
    end else begin
      div <= slot_end ? '0 : div + 1'b1;
      if (slot_end) begin
        sc <= (sc >= dmask) ? 4'd0 : sc + 4'd1;
        if (!mode[1]) begin
          prev[row] <= ret;
          rep[row]  <= (rep[row] & ret) | pick;
        end
      end
    end
  end

  // host registers and queue
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      mode  <= '0;
      addr  <= '0;
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovr   <= 1'b0;
      stb_q <= 1'b1;
      for (int k = 0; k < FIFO_DEPTH; k++) fifo[k] <= '0;
    end else begin
      stb_q <= ctrl_key;
      if (wr_cmd && din[7:4] == 4'h0) mode <= din[3:0];
      if (wr_cmd && din[7:4] == 4'h8) addr <= din[3:0];
      else if (wr_dat && !mode[3]) addr <= (addr + 4'd1) & dmask;
      if (do_push) begin
        fifo[wp] <= pdata;
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(pop);
      if (push && full) ovr <= 1'b1;
      else if (rd_st) ovr <= 1'b0;
    end
  end

  // display RAM
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int j = 0; j < 16; j++) ram[j] <= '0;
    end else if (wr_dat) begin
      if (!mode[3]) ram[addr] <= din;
      else begin
        for (int j = 0; j < 15; j++)
          if (5'(j) < ndig - 5'd1) ram[j] <= ram[j + 1];
        ram[dmask] <= din;
      end
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(FIFO_DEPTH));
  assert_full_push_ovr_R8: assert property (@(posedge clk) disable iff (rst)
    (full && push) |=> ovr);
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovr && !rd_st) |=> ovr);
  assert_status_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_st && !push) |=> !ovr);
  assert_blank_on_step_R13: assert property (@(posedge clk) disable iff (rst)
    !$stable(sc) |-> blank);
  assert_decoded_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    mode[0] |-> $onehot(scan));
  assert_addr_advance_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_dat && !mode[3] && !wr_cmd) |=> addr == (($past(addr) + 4'd1) & $past(dmask)));
endmodule

// File: tb/tb_kbd_disp_ctrl.sv
module tb_kbd_disp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int SCAN8 = 8 * DIV;
  // [15:13] row [12:10] column [9] shift [8] ctrl [7:0] expected entry
  localparam logic [15:0] KVEC [4] = '{16'h0000, 16'hAC2B, 16'hFA7E, 16'h5FD7};

  logic clk = 0, rst = 1;
  logic cs_n = 1, rd_n = 1, wr_n = 1, a0 = 0;
  logic [7:0] din = 0, dout, ret, ret_drv = 0;
  logic irq, blank, shift_key = 0, ctrl_key = 1;
  logic [3:0] scan, disp_hi, disp_lo;
  logic key_en = 0;
  logic [2:0] krow = 0, kcol = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign ret = key_en ? ((scan[2:0] == krow) ? (8'd1 << kcol) : 8'd0) : ret_drv;

  kbd_disp_ctrl #(.SCAN_DIV(DIV), .FIFO_DEPTH(8)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .din(din), .dout(dout), .irq(irq), .scan(scan), .ret(ret),
    .shift_key(shift_key), .ctrl_key(ctrl_key), .disp_hi(disp_hi),
    .disp_lo(disp_lo), .blank(blank));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d, input logic sel_n = 0);
    @(negedge clk);
    cs_n = sel_n; wr_n = 0; a0 = a; din = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d, input logic sel_n = 0);
    @(negedge clk);
    cs_n = sel_n; rd_n = 0; a0 = a;
    #1 d = dout;
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [7:0] v);
    @(negedge clk);
    ret_drv = v; ctrl_key = 0;
    @(negedge clk);
    ctrl_key = 1;
  endtask

  task automatic check_digit(input logic [3:0] pos, input logic [7:0] exp, input string req);
    int guard = 0;
    while (scan != pos && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check({disp_hi, disp_lo} == exp, req, {disp_hi, disp_lo}, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0] seen, last;
    int blanks, steps, bad, max_scan;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    check(scan == 0, "R1 scan", scan, 0);
    check(blank == 1, "R1 blank", blank, 1);
    check(irq == 0, "R1 irq", irq, 0);
    check({disp_hi, disp_lo} == 0, "R1 display", {disp_hi, disp_lo}, 0);
    bus_read(1, d);
    check(d == 8'h00, "R1 status", d, 0);

    // R6 scanned keys walked from the vector table
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      krow = KVEC[v][15:13]; kcol = KVEC[v][12:10];
      shift_key = KVEC[v][9]; ctrl_key = KVEC[v][8];
      key_en = 1;
      idle(3 * SCAN8);
      check(irq == 1, "R4 irq with entry", irq, 1);
      bus_read(1, d);
      check(d == 8'h01, "R6 held key gives one entry", d, 1);
      bus_read(0, d);
      check(d == KVEC[v][7:0], "R6 key code", d, KVEC[v][7:0]);
      key_en = 0; shift_key = 0; ctrl_key = 1;
      #1 check(irq == 0, "R4 irq empty", irq, 0);
      idle(2 * SCAN8);
    end

    // R6 debounce: closure seen on only one scan
    @(negedge clk);
    krow = 3; kcol = 1; key_en = 1;
    idle(SCAN8);
    key_en = 0;
    idle(2 * SCAN8);
    bus_read(1, d);
    check(d == 8'h00, "R6 single-scan press rejected", d, 0);

    // R7 strobed input, R8 overrun
    bus_write(1, 8'h02);
    for (int i = 0; i < 8; i++) strobe(8'hA0 + 8'(i));
    bus_read(1, d);
    check(d == 8'h08, "R7 strobed count", d, 8);
    strobe(8'h55);
    bus_read(1, d);
    check(d == 8'h88, "R8 overrun on full push", d, 8'h88);
    bus_read(1, d);
    check(d == 8'h08, "R3 status read clears overrun", d, 8'h08);
    bus_read(0, d, 1);
    bus_read(1, d);
    check(d == 8'h08, "R5 deselected read ignored", d, 8'h08);
    for (int i = 0; i < 8; i++) begin
      bus_read(0, d);
      check(d == 8'hA0 + 8'(i), "R2 queue order", d, 8'hA0 + i);
    end
    bus_read(1, d);
    check(d == 8'h00, "R2 queue drained", d, 0);

    // R9 left entry, address set and wrap; R11 nibbles
    bus_write(1, 8'h00);
    bus_write(1, 8'h82);
    bus_write(0, 8'hA5);
    bus_write(0, 8'h3C);
    bus_write(0, 8'hEE, 1);
    check_digit(2, 8'hA5, "R11 digit 2");
    check_digit(3, 8'h3C, "R9 address advance");
    check_digit(4, 8'h00, "R5 deselected write ignored");
    bus_write(1, 8'h87);
    bus_write(0, 8'h5A);
    bus_write(0, 8'h99);
    check_digit(7, 8'h5A, "R9 digit 7");
    check_digit(0, 8'h99, "R9 address wrap");

    // R10 right entry
    bus_write(1, 8'h08);
    bus_write(0, 8'h11);
    bus_write(0, 8'h22);
    check_digit(7, 8'h22, "R10 last digit");
    check_digit(6, 8'h11, "R10 shift one");
    check_digit(5, 8'h5A, "R10 shift two");

    // R12 and R13 encoded 8-digit scan with blanking
    bus_write(1, 8'h00);
    idle(SCAN8);
    blanks = 0; steps = 0; bad = 0; max_scan = 0;
    @(negedge clk);
    last = scan;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (blank) blanks++;
      if (scan != last) begin
        steps++;
        if (!blank) bad++;
      end
      if (int'(scan) > max_scan) max_scan = int'(scan);
      last = scan;
    end
    check(blanks == 64 / DIV, "R13 blank once per slot", blanks, 64 / DIV);
    check(bad == 0, "R13 blank on scan step", bad, 0);
    check(steps == 64 / DIV, "R12 step every SCAN_DIV", steps, 64 / DIV);
    check(max_scan == 7, "R12 encoded 8-digit range", max_scan, 7);

    // R12 sixteen digits
    bus_write(1, 8'h04);
    max_scan = 0;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (int'(scan) > max_scan) max_scan = int'(scan);
    end
    check(max_scan == 15, "R12 encoded 16-digit range", max_scan, 15);

    // R12 decoded
    bus_write(1, 8'h01);
    idle(2 * DIV * 16);
    seen = 0; bad = 0;
    for (int c = 0; c < 4 * DIV; c++) begin
      @(negedge clk);
      seen |= scan;
      if ($countones(scan) != 1) bad++;
    end
    check(bad == 0, "R12 decoded one-hot", bad, 0);
    check(seen == 4'hF, "R12 decoded covers four", seen, 4'hF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule